// File: doc/BRIEF.md
# Path overhead byte source selector

This block produces the K3, N1, F2 and F3 path overhead bytes for each outgoing frame. A five-bit configuration word chooses, separately for each byte, where it comes from: the matching byte carried on the parallel telecom bus, a byte picked out of a serial path-overhead stream, a CPU-written holding register (K3 only), or a byte rebuilt from a 64 kbit/s serial order-wire line (F2 from line 0, F3 from line 1). N1 is passed on untouched, with no tandem-connection processing of its own.

The serial sources are deserialised continuously into holding bytes. On each `frame_tick` all four outputs are loaded together from their selected sources, and `out_valid` pulses one cycle later. Between ticks the outputs do not move, so the configuration, the register and the serial streams may change at any moment without a torn or half-updated byte reaching the frame. The bus source only has meaning in add-drop mode. In terminal mode a byte that is set to use the bus gets a substitute value instead, chosen by the parameter `FALLBACK_SERIAL`.

Top module: `poh_src_sel`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, all four byte outputs read 0 and `out_valid` is 0.
- R2: `out_valid` is high in exactly the cycle after a cycle with `frame_tick` high, and low otherwise. The four outputs take their new values in that same cycle.
- R3: K3 uses `src_cfg[1:0]`. 00 selects `bus_k3`, 01 selects the serial path-overhead K3 byte, and 10 or 11 selects `k3_reg` as sampled at the tick.
- R4: N1 uses `src_cfg[2]`. 0 selects `bus_n1` and 1 selects the serial path-overhead N1 byte. The byte is passed on unchanged.
- R5: F2 uses `src_cfg[3]` and F3 uses `src_cfg[4]`. 0 selects `bus_f2` or `bus_f3`, and 1 selects the order-wire byte from line 0 or line 1.
- R6: When `add_drop_mode` is 0, a byte set to its bus source outputs 0 if `FALLBACK_SERIAL`=0. If `FALLBACK_SERIAL`=1 it outputs that byte's own serial source instead: path overhead for K3 and N1, order wire for F2 and F3.
- R7: Serial path overhead arrives one bit per cycle with `spoh_en` high, most significant bit first. `spoh_fp` high marks the first bit of byte 0. Byte 7 is K3 and byte 8 is N1. A byte becomes the held serial value on its eighth bit. Bits before the first `spoh_fp`, and bits after byte 8 until the next `spoh_fp`, change nothing.
- R8: On each order-wire line, a bit with `ow_en[i]` and `ow_sync[i]` both high is the most significant bit of a new byte. The held byte is replaced when the eighth bit of that byte arrives. Bits that arrive with no sync in progress, or in an unfinished byte, change nothing.
- R9: A serial byte that completes on the same clock edge as a tick is not used for that tick. It is first inserted at the next tick.
- R10: Changes of `src_cfg`, `add_drop_mode`, `k3_reg`, the bus bytes or the serial inputs between ticks leave the four outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| add_drop_mode | input | 1 | 1 = add-drop mode, 0 = terminal mode |
| src_cfg | input | 5 | Source selection per byte (see R3, R4, R5) |
| k3_reg | input | 8 | CPU-written K3 value |
| bus_k3 | input | 8 | K3 byte from the telecom bus |
| bus_n1 | input | 8 | N1 byte from the telecom bus |
| bus_f2 | input | 8 | F2 byte from the telecom bus |
| bus_f3 | input | 8 | F3 byte from the telecom bus |
| spoh_en | input | 1 | Serial path-overhead bit valid |
| spoh_fp | input | 1 | Marks the first bit of serial byte 0 |
| spoh_bit | input | 1 | Serial path-overhead data |
| ow_en | input | 2 | Order-wire bit valid, per line |
| ow_sync | input | 2 | Order-wire byte start, per line |
| ow_bit | input | 2 | Order-wire data, per line |
| frame_tick | input | 1 | Overhead insertion slot strobe |
| k3_out | output | 8 | Inserted K3 byte |
| n1_out | output | 8 | Inserted N1 byte |
| f2_out | output | 8 | Inserted F2 byte |
| f3_out | output | 8 | Inserted F3 byte |
| out_valid | output | 1 | New bytes present this cycle |

## Verification
The assertions assume that `frame_tick` is a clean synchronous strobe and that `rst_n` is asserted from the first clock edge. The outputs are only tested against the bus, the register and zero, so they take no position on how the serial streams are framed. The stimulus drives every input half a cycle away from the sampling edge. It gives `frame_tick` one-cycle pulses at least twenty cycles apart. The serial path-overhead frame pulse always lands on the first bit of a 72-bit frame, followed by random filler bits that the block must ignore. Each order-wire byte starts with its sync bit, and a stray unsynchronised bit follows it.

// File: rtl/poh_src_sel.sv
module poh_src_sel #(
  parameter int BW              = 8,
  parameter int POH_BYTES       = 9,
  parameter int K3_POS          = 7,
  parameter int N1_POS          = 8,
  parameter bit FALLBACK_SERIAL = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          add_drop_mode,
  input  logic [4:0]    src_cfg,
  input  logic [BW-1:0] k3_reg,
  input  logic [BW-1:0] bus_k3,
  input  logic [BW-1:0] bus_n1,
  input  logic [BW-1:0] bus_f2,
  input  logic [BW-1:0] bus_f3,
  input  logic          spoh_en,
  input  logic          spoh_fp,
  input  logic          spoh_bit,
  input  logic [1:0]    ow_en,
  input  logic [1:0]    ow_sync,
  input  logic [1:0]    ow_bit,
  input  logic          frame_tick,
  output logic [BW-1:0] k3_out,
  output logic [BW-1:0] n1_out,
  output logic [BW-1:0] f2_out,
  output logic [BW-1:0] f3_out,
  output logic          out_valid
);
  localparam int IW   = $clog2(POH_BYTES + 1);
  localparam int CW   = $clog2(BW);
  localparam int NOW  = 2;

  // serial path overhead deserialiser
  logic          sp_lock;
  logic [IW-1:0] sp_idx;
  logic [CW-1:0] sp_cnt;
  logic [BW-1:0] sp_sh, k3_ser, n1_ser;
  wire  [BW-1:0] sp_byte = {sp_sh[BW-2:0], spoh_bit};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_lock <= 1'b0;
      sp_idx  <= '0;
      sp_cnt  <= '0;
      sp_sh   <= '0;
      k3_ser  <= '0;
      n1_ser  <= '0;
    end else if (spoh_en) begin
      if (spoh_fp) begin
        sp_lock <= 1'b1;
        sp_idx  <= '0;
        sp_cnt  <= CW'(1);
        sp_sh   <= {{(BW-1){1'b0}}, spoh_bit};
      end else if (sp_lock) begin
        sp_sh <= sp_byte;
        if (sp_cnt == CW'(BW-1)) begin
          sp_cnt <= '0;
          sp_idx <= sp_idx + IW'(1);
          if (sp_idx == IW'(K3_POS)) k3_ser <= sp_byte;
          if (sp_idx == IW'(N1_POS)) n1_ser <= sp_byte;
          if (sp_idx == IW'(POH_BYTES-1)) sp_lock <= 1'b0;
        end else begin
          sp_cnt <= sp_cnt + CW'(1);
        end
      end
    end
  end

  // 64 kbit/s order-wire deserialisers, line 0 -> F2, line 1 -> F3
  logic [NOW*BW-1:0] ow_held;

  for (genvar i = 0; i < NOW; i++) begin : g_ow
    logic          act;
    logic [CW-1:0] cnt;
    logic [BW-1:0] sh, held;
    wire  [BW-1:0] nb = {sh[BW-2:0], ow_bit[i]};

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        act  <= 1'b0;
        cnt  <= '0;
        sh   <= '0;
        held <= '0;
      end else if (ow_en[i]) begin
        if (ow_sync[i]) begin
          act <= 1'b1;
          cnt <= CW'(1);
          sh  <= {{(BW-1){1'b0}}, ow_bit[i]};
        end else if (act) begin
          sh <= nb;
          if (cnt == CW'(BW-1)) begin
            held <= nb;
            act  <= 1'b0;
            cnt  <= '0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
      end
    end

    assign ow_held[i*BW +: BW] = held;
  end

  // source selection
  wire [BW-1:0] ow0 = ow_held[0 +: BW];
  wire [BW-1:0] ow1 = ow_held[BW +: BW];

  wire [BW-1:0] k3_bus = add_drop_mode ? bus_k3 : (FALLBACK_SERIAL ? k3_ser : '0);
  wire [BW-1:0] n1_bus = add_drop_mode ? bus_n1 : (FALLBACK_SERIAL ? n1_ser : '0);
  wire [BW-1:0] f2_bus = add_drop_mode ? bus_f2 : (FALLBACK_SERIAL ? ow0 : '0);
  wire [BW-1:0] f3_bus = add_drop_mode ? bus_f3 : (FALLBACK_SERIAL ? ow1 : '0);

  logic [BW-1:0] k3_nx;
  always_comb begin
    case (src_cfg[1:0])
      2'b00:   k3_nx = k3_bus;
      2'b01:   k3_nx = k3_ser;
      default: k3_nx = k3_reg;
    endcase
  end

  wire [BW-1:0] n1_nx = src_cfg[2] ? n1_ser : n1_bus;
  wire [BW-1:0] f2_nx = src_cfg[3] ? ow0    : f2_bus;
  wire [BW-1:0] f3_nx = src_cfg[4] ? ow1    : f3_bus;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      k3_out    <= '0;
      n1_out    <= '0;
      f2_out    <= '0;
      f3_out    <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= frame_tick;
      if (frame_tick) begin
        k3_out <= k3_nx;
        n1_out <= n1_nx;
        f2_out <= f2_nx;
        f3_out <= f3_nx;
      end
    end
  end
endmodule

module poh_src_sel_chk #(
  parameter int BW              = 8,
  parameter bit FALLBACK_SERIAL = 1'b0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          add_drop_mode,
  input logic [4:0]    src_cfg,
  input logic [BW-1:0] k3_reg,
  input logic [BW-1:0] bus_n1,
  input logic          frame_tick,
  input logic [BW-1:0] k3_out,
  input logic [BW-1:0] n1_out,
  input logic [BW-1:0] f2_out,
  input logic [BW-1:0] f3_out,
  input logic          out_valid
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && k3_out == '0 && n1_out == '0 && f2_out == '0 && f3_out == '0));

  assert_valid_after_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick |=> out_valid);

  assert_no_valid_without_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> !out_valid);

  assert_hold_between_ticks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> ($stable(k3_out) && $stable(n1_out) && $stable(f2_out) && $stable(f3_out)));

  assert_k3_register_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && src_cfg[1]) |=> k3_out == $past(k3_reg));

  assert_n1_bus_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && add_drop_mode && !src_cfg[2]) |=> n1_out == $past(bus_n1));

  if (!FALLBACK_SERIAL) begin : g_zero
    assert_terminal_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_tick && !add_drop_mode && !src_cfg[2]) |=> n1_out == '0);
  end
endmodule

bind poh_src_sel poh_src_sel_chk #(.BW(BW), .FALLBACK_SERIAL(FALLBACK_SERIAL)) u_chk (
  .clk(clk), .rst_n(rst_n), .add_drop_mode(add_drop_mode), .src_cfg(src_cfg),
  .k3_reg(k3_reg), .bus_n1(bus_n1), .frame_tick(frame_tick),
  .k3_out(k3_out), .n1_out(n1_out), .f2_out(f2_out), .f3_out(f3_out),
  .out_valid(out_valid)
);

// File: tb/poh_src_sel_tb.sv
module poh_src_sel_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic add_drop_mode = 1'b0;
  logic [4:0] src_cfg = '0;
  logic [7:0] k3_reg = '0, bus_k3 = '0, bus_n1 = '0, bus_f2 = '0, bus_f3 = '0;
  logic spoh_en = 1'b0, spoh_fp = 1'b0, spoh_bit = 1'b0;
  logic [1:0] ow_en = '0, ow_sync = '0, ow_bit = '0;
  logic frame_tick = 1'b0;
  logic [7:0] o_k3 [2], o_n1 [2], o_f2 [2], o_f3 [2];
  logic o_v [2];

  always #10 clk = ~clk;

  poh_src_sel #(.FALLBACK_SERIAL(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .add_drop_mode(add_drop_mode), .src_cfg(src_cfg),
    .k3_reg(k3_reg), .bus_k3(bus_k3), .bus_n1(bus_n1), .bus_f2(bus_f2), .bus_f3(bus_f3),
    .spoh_en(spoh_en), .spoh_fp(spoh_fp), .spoh_bit(spoh_bit),
    .ow_en(ow_en), .ow_sync(ow_sync), .ow_bit(ow_bit), .frame_tick(frame_tick),
    .k3_out(o_k3[0]), .n1_out(o_n1[0]), .f2_out(o_f2[0]), .f3_out(o_f3[0]), .out_valid(o_v[0]));

  poh_src_sel #(.FALLBACK_SERIAL(1'b1)) u_dut_fb (
    .clk(clk), .rst_n(rst_n), .add_drop_mode(add_drop_mode), .src_cfg(src_cfg),
    .k3_reg(k3_reg), .bus_k3(bus_k3), .bus_n1(bus_n1), .bus_f2(bus_f2), .bus_f3(bus_f3),
    .spoh_en(spoh_en), .spoh_fp(spoh_fp), .spoh_bit(spoh_bit),
    .ow_en(ow_en), .ow_sync(ow_sync), .ow_bit(ow_bit), .frame_tick(frame_tick),
    .k3_out(o_k3[1]), .n1_out(o_n1[1]), .f2_out(o_f2[1]), .f3_out(o_f3[1]), .out_valid(o_v[1]));

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int ser[2];            // 0: K3, 1: N1 serial bytes
  int owh[2];            // order-wire held bytes
  bit sp_lock = 0;
  int sp_idx = 0;
  bit sp_q[$];
  bit ow_act[2];
  bit ow_q0[$], ow_q1[$];
  int  e_val [2][4];
  string e_tag [2][4];
  bit  e_v = 0;
  bit  in_rst = 1;

  function automatic int pack(bit q[$]);
    int v = 0;
    foreach (q[k]) v = (v << 1) | q[k];
    return v;
  endfunction

  function automatic int pick(int f, int fb, output string tg);
    int own, bus;
    bit ser_sel;
    if (f == 0) begin
      if (src_cfg[1]) begin tg = "R3"; return k3_reg; end
      if (src_cfg[0]) begin tg = "R7"; return ser[0]; end
      own = ser[0]; bus = bus_k3;
      if (add_drop_mode) begin tg = "R3"; return bus; end
    end else if (f == 1) begin
      if (src_cfg[2]) begin tg = "R7"; return ser[1]; end
      own = ser[1]; bus = bus_n1;
      if (add_drop_mode) begin tg = "R4"; return bus; end
    end else begin
      ser_sel = src_cfg[f+1];
      own = owh[f-2]; bus = (f == 2) ? bus_f2 : bus_f3;
      if (ser_sel) begin tg = "R8"; return own; end
      if (add_drop_mode) begin tg = "R5"; return bus; end
    end
    tg = "R6";
    return fb ? own : 0;
  endfunction

  always @(posedge clk) begin
    bit comp [4];
    string t;
    int v;
    comp = '{0, 0, 0, 0};
    if (!rst_n) begin
      in_rst = 1;
      ser = '{0, 0}; owh = '{0, 0};
      sp_lock = 0; sp_idx = 0; sp_q.delete();
      ow_act = '{0, 0}; ow_q0.delete(); ow_q1.delete();
      e_v = 0;
      for (int d = 0; d < 2; d++) for (int f = 0; f < 4; f++) begin e_val[d][f] = 0; e_tag[d][f] = "R1"; end
    end else begin
      e_v = frame_tick;
      for (int d = 0; d < 2; d++)
        for (int f = 0; f < 4; f++)
          if (frame_tick) begin
            v = pick(f, d, t);
            e_val[d][f] = v; e_tag[d][f] = t;
          end else e_tag[d][f] = in_rst ? "R1" : "R10";
      in_rst = 0;
      if (spoh_en) begin
        if (spoh_fp) begin
          sp_lock = 1; sp_idx = 0; sp_q.delete(); sp_q.push_back(spoh_bit);
        end else if (sp_lock) begin
          sp_q.push_back(spoh_bit);
          if (sp_q.size() == 8) begin
            if (sp_idx == 7) begin ser[0] = pack(sp_q); comp[0] = 1; end
            if (sp_idx == 8) begin ser[1] = pack(sp_q); comp[1] = 1; end
            sp_idx++; sp_q.delete();
            if (sp_idx == 9) sp_lock = 0;
          end
        end
      end
      if (ow_en[0]) begin
        if (ow_sync[0]) begin ow_act[0] = 1; ow_q0.delete(); ow_q0.push_back(ow_bit[0]); end
        else if (ow_act[0]) begin
          ow_q0.push_back(ow_bit[0]);
          if (ow_q0.size() == 8) begin owh[0] = pack(ow_q0); ow_act[0] = 0; ow_q0.delete(); comp[2] = 1; end
        end
      end
      if (ow_en[1]) begin
        if (ow_sync[1]) begin ow_act[1] = 1; ow_q1.delete(); ow_q1.push_back(ow_bit[1]); end
        else if (ow_act[1]) begin
          ow_q1.push_back(ow_bit[1]);
          if (ow_q1.size() == 8) begin owh[1] = pack(ow_q1); ow_act[1] = 0; ow_q1.delete(); comp[3] = 1; end
        end
      end
      if (frame_tick)
        for (int d = 0; d < 2; d++)
          for (int f = 0; f < 4; f++)
            if (comp[f] && e_tag[d][f] != "R3" && e_tag[d][f] != "R4" && e_tag[d][f] != "R5")
              e_tag[d][f] = {e_tag[d][f], " R9"};
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (cyc > 0 && !finished)
      for (int d = 0; d < 2; d++) begin
        chk(in_rst ? "R1" : "R2", $sformatf("dut%0d valid", d), o_v[d], e_v);
        chk(e_tag[d][0], $sformatf("dut%0d k3", d), o_k3[d], e_val[d][0]);
        chk(e_tag[d][1], $sformatf("dut%0d n1", d), o_n1[d], e_val[d][1]);
        chk(e_tag[d][2], $sformatf("dut%0d f2", d), o_f2[d], e_val[d][2]);
        chk(e_tag[d][3], $sformatf("dut%0d f3", d), o_f3[d], e_val[d][3]);
      end
  end

  // serial stimulus: path overhead and two order-wire lines
  int sp_pos = 0, sp_frm = 0;
  int ow_pos [2] = '{9, 9};
  logic [7:0] ow_byte [2];
  always @(negedge clk) begin
    logic [7:0] b;
    spoh_en = ($urandom % 3) != 0;
    spoh_fp = 1'b0;
    if (spoh_en) begin
      if (sp_pos < 72) begin
        b = 8'(sp_frm * 37 + (sp_pos / 8) * 11 + 5);
        spoh_bit = b[7 - (sp_pos % 8)];
        spoh_fp  = (sp_pos == 0);
      end else spoh_bit = 1'($urandom);
      sp_pos++;
      if (sp_pos == 84) begin sp_pos = 0; sp_frm++; end
    end
    for (int i = 0; i < 2; i++) begin
      ow_en[i] = (cyc % (13 + 5 * i)) == 0;
      ow_sync[i] = 1'b0;
      if (ow_en[i]) begin
        if (ow_pos[i] >= 9) begin ow_pos[i] = 0; ow_byte[i] = 8'($urandom); end
        if (ow_pos[i] < 8) begin
          ow_bit[i]  = ow_byte[i][7 - ow_pos[i]];
          ow_sync[i] = (ow_pos[i] == 0);
        end else ow_bit[i] = 1'($urandom);
        ow_pos[i]++;
      end
    end
  end

  always @(posedge clk) cyc++;

  task automatic shuffle();
    src_cfg = 5'($urandom); add_drop_mode = 1'($urandom);
    k3_reg = 8'($urandom); bus_k3 = 8'($urandom); bus_n1 = 8'($urandom);
    bus_f2 = 8'($urandom); bus_f3 = 8'($urandom);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    for (int fr = 0; fr < 600; fr++) begin
      int gap = 20 + ($urandom % 130);
      for (int c = 0; c < gap; c++) begin
        @(negedge clk);
        if (($urandom % 40) == 0) shuffle();
      end
      @(negedge clk);
      shuffle();
      frame_tick = 1'b1;
      @(negedge clk);
      frame_tick = 1'b0;
      if (fr == 300) begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
      end
    end
    repeat (4) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc >= 190000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog R2 act=%0d exp=done", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule